// File: doc/BRIEF.md
# PWM Compare Register Update Controller

This block sits between a processor register bus and a PWM counter core. It keeps four 16-bit compare values: two reset points (RA, RB) and two set points (SA, SB). Each value has a shadow copy, which software writes and reads back, and an active copy, which the counter core uses. It also keeps an 8-bit control byte. The control byte holds the fifty-percent duplication mode, the auto-lock and lock controls, the ramp-mode selection, the output polarity and a clock-select bit. The ramp mode, polarity and clock select are passed on to the waveform core.

Shadow values move to the active copies only on an end-of-cycle strobe from the counter core, so a PWM period never runs on a half-written set of compare values. Software uses lock to stage a whole new set. With auto-lock, a write to RB marks the staged set as complete, and it commits at the next period boundary. Fifty-percent mode lets software program only RB and SB. The block mirrors them into RA and SA.

Top module: `pwm_cmp_update`

## Requirements
- R1: After a synchronous reset, the control byte and all shadow and active compare values are 0. So ramp_mode, pol_high and clk_sel are 0, and every act_* output is 0.
- R2: A write with wr_addr 0, 1, 2 or 3 stores wr_data into the RA, RB, SA or SB shadow respectively. Address 4 stores wr_data[7:0] into the control byte. rd_data returns the shadow (or the control byte, zero-extended) at rd_addr. Addresses 5 to 7 read as 0, and writes to them change nothing.
- R3: The control byte fields are bit 7 fifty-percent, bit 6 auto-lock, bit 5 lock, bits 4:3 ramp mode, bit 2 polarity and bit 1 clock select. The ramp mode (00 one ramp, 01 two ramp, 10 four ramp, 11 center aligned), the polarity (1 = active high) and the clock select drive ramp_mode, pol_high and clk_sel from the cycle after the write.
- R4: With lock and auto-lock both clear, a cycle with cycle_end high copies all four shadows into the active registers. The active values are visible from the next cycle. Without cycle_end the active registers hold.
- R5: With lock set and auto-lock clear, no active register changes, whatever strobes or writes arrive.
- R6: Once lock is cleared, the first cycle_end copies all shadow values staged while locked, together.
- R7: With auto-lock set, cycle_end copies the shadows only if RB was the most recent compare write accepted. A later accepted write to RA, SA or SB cancels that.
- R8: When auto-lock and lock are both set, the auto-lock rule of R7 decides, and lock has no effect.
- R9: In fifty-percent mode, writes to RA and SA are ignored. A write to RB also loads its value into the RA shadow and copies the SB shadow into the SA shadow.
- R10: A write and a cycle_end in the same cycle transfer the shadow value from before that write. The new value reaches the active register at a later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read-back address |
| rd_data | output | 16 | Read-back data (shadow values, control byte) |
| cycle_end | input | 1 | End-of-PWM-cycle strobe from the counter core |
| act_ra | output | 16 | Active first reset point |
| act_rb | output | 16 | Active second reset point |
| act_sa | output | 16 | Active first set point |
| act_sb | output | 16 | Active second set point |
| ramp_mode | output | 2 | Ramp mode to the waveform core |
| pol_high | output | 1 | Output polarity, 1 = active high |
| clk_sel | output | 1 | Clock select to the waveform core |

## Verification
A wrong shadow value or a lost fifty-percent mirror shows on rd_data in the cycle after the write. It shows on the act_* outputs at the next permitted strobe. A wrong RB-last flag or a wrong gate decision does not show up until a cycle_end: the active values then either move when they should hold or stay stale when they should update. Every strobe therefore has to be followed by a comparison of all four active outputs. Stimulus that interleaves RB writes with other compare writes under auto-lock is what exposes faults in the flag.

// File: rtl/cmp_pkg.sv
`timescale 1ns/1ps
package cmp_pkg;
    localparam int CMP_W  = 16;
    localparam int ADDR_W = 3;
    localparam int N_CMP  = 4;
    localparam int CFG_W  = 8;
    localparam int IDX_W  = $clog2(N_CMP);

    localparam logic [ADDR_W-1:0] A_RA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_RB  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_SB  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CFG = 3'd4;

    typedef enum logic [1:0] {
        RAMP_ONE    = 2'b00,
        RAMP_TWO    = 2'b01,
        RAMP_FOUR   = 2'b10,
        RAMP_CENTER = 2'b11
    } ramp_e;

    // Field order fixes bit positions: fifty is bit 7, spare is bit 0.
    typedef struct packed {
        logic  fifty;
        logic  alock;
        logic  lock;
        ramp_e ramp;
        logic  pol_hi;
        logic  clk_sel;
        logic  spare;
    } cfg_t;

    function automatic logic is_cmp_addr(input logic [ADDR_W-1:0] a);
        return a < ADDR_W'(N_CMP);
    endfunction

    // Auto-lock prevails over lock.
    function automatic logic xfer_allowed(input cfg_t c, input logic rb_last);
        if (c.alock)
            return rb_last;
        return !c.lock;
    endfunction
endpackage

// File: rtl/cmp_cfg_reg.sv
`timescale 1ns/1ps
module cmp_cfg_reg
    import cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (we && addr == A_CFG)
            cfg <= cfg_t'(wdata);
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_CFG) |=> (cfg == cfg_t'($past(wdata))))
        else $error("config byte not loaded"); // R3
endmodule

// File: rtl/cmp_shadow_bank.sv
`timescale 1ns/1ps
module cmp_shadow_bank
    import cmp_pkg::*;
#(
    parameter int DATA_W = CMP_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          fifty,
    input  logic                          flag_clr,
    output logic [N_CMP-1:0][DATA_W-1:0]  sh,
    output logic                          rb_last
);
    localparam logic [IDX_W-1:0] I_RA = A_RA[IDX_W-1:0];
    localparam logic [IDX_W-1:0] I_SA = A_SA[IDX_W-1:0];
    localparam logic [IDX_W-1:0] I_SB = A_SB[IDX_W-1:0];

    logic accept;
    logic is_rb;
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx    = addr[IDX_W-1:0];
        is_rb  = (addr == A_RB);
        accept = we && is_cmp_addr(addr) &&
                 !(fifty && (addr == A_RA || addr == A_SA));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            rb_last <= 1'b0;
        end else begin
            if (flag_clr)
                rb_last <= 1'b0;
            if (accept) begin
                sh[idx] <= wdata;
                rb_last <= is_rb;
                if (fifty && is_rb) begin
                    sh[I_RA] <= wdata;
                    sh[I_SA] <= sh[I_SB];
                end
            end
        end
    end

    AST_FIFTY_MIRROR: assert property (@(posedge clk) disable iff (rst)
        (we && fifty && addr == A_RB) |=>
            (sh[I_RA] == $past(wdata) && sh[I_SA] == $past(sh[I_SB])))
        else $error("fifty mirror missing"); // R9
    AST_FIFTY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (we && fifty && (addr == A_RA || addr == A_SA)) |=> $stable(sh[I_RA]) && $stable(sh[I_SA]))
        else $error("fifty mode accepted RA/SA write"); // R9
    AST_RB_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (we && is_rb) |=> rb_last)
        else $error("RB flag not set"); // R7
endmodule

// File: rtl/cmp_xfer_gate.sv
`timescale 1ns/1ps
module cmp_xfer_gate
    import cmp_pkg::*;
(
    input  logic cycle_end,
    input  cfg_t cfg,
    input  logic rb_last,
    output logic xfer,
    output logic flag_clr
);
    always_comb begin
        xfer     = cycle_end && xfer_allowed(cfg, rb_last);
        flag_clr = xfer && cfg.alock;
    end
endmodule

// File: rtl/cmp_active_bank.sv
`timescale 1ns/1ps
module cmp_active_bank
    import cmp_pkg::*;
#(
    parameter int DATA_W = CMP_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          xfer,
    input  logic [N_CMP-1:0][DATA_W-1:0]  sh,
    output logic [N_CMP-1:0][DATA_W-1:0]  act
);
    for (genvar g = 0; g < N_CMP; g++) begin : g_act
        always_ff @(posedge clk) begin
            if (rst)
                act[g] <= '0;
            else if (xfer)
                act[g] <= sh[g];
        end
    end
endmodule

// File: rtl/pwm_cmp_update.sv
`timescale 1ns/1ps
module pwm_cmp_update
    import cmp_pkg::*;
#(
    parameter int DATA_W = CMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              cycle_end,
    output logic [DATA_W-1:0] act_ra,
    output logic [DATA_W-1:0] act_rb,
    output logic [DATA_W-1:0] act_sa,
    output logic [DATA_W-1:0] act_sb,
    output logic [1:0]        ramp_mode,
    output logic              pol_high,
    output logic              clk_sel
);
    cfg_t cfg;
    logic rb_last;
    logic xfer;
    logic flag_clr;
    logic [N_CMP-1:0][DATA_W-1:0] sh;
    logic [N_CMP-1:0][DATA_W-1:0] act;

    cmp_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .addr  (wr_addr),
        .wdata (wr_data[CFG_W-1:0]),
        .cfg   (cfg)
    );

    cmp_shadow_bank #(.DATA_W(DATA_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_en),
        .addr     (wr_addr),
        .wdata    (wr_data),
        .fifty    (cfg.fifty),
        .flag_clr (flag_clr),
        .sh       (sh),
        .rb_last  (rb_last)
    );

    cmp_xfer_gate u_gate (
        .cycle_end (cycle_end),
        .cfg       (cfg),
        .rb_last   (rb_last),
        .xfer      (xfer),
        .flag_clr  (flag_clr)
    );

    cmp_active_bank #(.DATA_W(DATA_W)) u_active (
        .clk  (clk),
        .rst  (rst),
        .xfer (xfer),
        .sh   (sh),
        .act  (act)
    );

    always_comb begin
        act_ra    = act[A_RA[IDX_W-1:0]];
        act_rb    = act[A_RB[IDX_W-1:0]];
        act_sa    = act[A_SA[IDX_W-1:0]];
        act_sb    = act[A_SB[IDX_W-1:0]];
        ramp_mode = cfg.ramp;
        pol_high  = cfg.pol_hi;
        clk_sel   = cfg.clk_sel;
        if (is_cmp_addr(rd_addr))
            rd_data = sh[rd_addr[IDX_W-1:0]];
        else if (rd_addr == A_CFG)
            rd_data = DATA_W'(cfg);
        else
            rd_data = '0;
    end

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !cycle_end |=> $stable(act))
        else $error("active changed without strobe"); // R4
    AST_UNLOCKED_XFER: assert property (@(posedge clk) disable iff (rst)
        (cycle_end && !cfg.lock && !cfg.alock) |=> (act == $past(sh)))
        else $error("unlocked strobe did not transfer"); // R4
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg.lock && !cfg.alock) |=> $stable(act))
        else $error("active changed under lock"); // R5
    AST_ALOCK_GATE: assert property (@(posedge clk) disable iff (rst)
        (cfg.alock && !rb_last) |=> $stable(act))
        else $error("auto-lock transfer without RB write"); // R7
    AST_ALOCK_PRIO: assert property (@(posedge clk) disable iff (rst)
        (cfg.alock && cfg.lock && cycle_end && rb_last) |=> (act == $past(sh)))
        else $error("lock overrode auto-lock"); // R8
endmodule

// File: tb/pwm_cmp_update_tb.sv
`timescale 1ns/1ps
module pwm_cmp_update_tb_top;
    localparam real HALF = 4.0;
    localparam int  WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        cycle_end = 1'b0;
    logic [15:0] act_ra, act_rb, act_sa, act_sb;
    logic [1:0]  ramp_mode;
    logic        pol_high, clk_sel;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    logic [15:0] m_sh  [4];
    logic [15:0] m_act [4];
    logic [7:0]  m_cfg;
    bit          m_flag;

    always #(HALF) clk = ~clk;

    pwm_cmp_update dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cycle_end(cycle_end),
        .act_ra(act_ra), .act_rb(act_rb), .act_sa(act_sa), .act_sb(act_sb),
        .ramp_mode(ramp_mode), .pol_high(pol_high), .clk_sel(clk_sel)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic bit gate_open();
        if (m_cfg[6]) return m_flag;
        return !m_cfg[5];
    endfunction

    task automatic model_step(input bit we, input logic [2:0] a, input logic [15:0] d, input bit ce);
        logic [15:0] old_sh [4];
        bit x;
        for (int i = 0; i < 4; i++) old_sh[i] = m_sh[i];
        x = ce && gate_open();
        if (x) for (int i = 0; i < 4; i++) m_act[i] = old_sh[i];
        if (x && m_cfg[6]) m_flag = 0;
        if (we) begin
            if (a == 3'd4) begin
                m_cfg = d[7:0];
            end else if (a < 3'd4 && !(m_cfg[7] && (a == 3'd0 || a == 3'd2))) begin
                m_sh[a[1:0]] = d;
                m_flag = (a == 3'd1);
                if (m_cfg[7] && a == 3'd1) begin
                    m_sh[0] = d;
                    m_sh[2] = old_sh[3];
                end
            end
        end
    endtask

    task automatic cyc(input bit we, input logic [2:0] a, input logic [15:0] d, input bit ce);
        wr_en = we; wr_addr = a; wr_data = d; cycle_end = ce;
        @(posedge clk);
        model_step(we, a, d, ce);
        @(negedge clk);
        wr_en = 0; cycle_end = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic cmp_model(input string tag);
        logic [15:0] v;
        chk({tag, " act_ra"}, act_ra, m_act[0]);
        chk({tag, " act_rb"}, act_rb, m_act[1]);
        chk({tag, " act_sa"}, act_sa, m_act[2]);
        chk({tag, " act_sb"}, act_sb, m_act[3]);
        chk({tag, " ramp"}, ramp_mode, m_cfg[4:3]);
        chk({tag, " pol"}, pol_high, m_cfg[2]);
        chk({tag, " clksel"}, clk_sel, m_cfg[1]);
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v);
            chk({tag, " readback"}, v, (i < 4) ? m_sh[i] : {8'h00, m_cfg});
        end
    endtask

    initial begin
        #(WD_CYCLES * 2 * HALF);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) begin m_sh[i] = '0; m_act[i] = '0; end
        m_cfg = '0; m_flag = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        chk("R1 act_ra", act_ra, 0); chk("R1 act_sb", act_sb, 0);
        chk("R1 ramp", ramp_mode, 0); chk("R1 pol", pol_high, 0); chk("R1 clksel", clk_sel, 0);
        rd(3'd1, v); chk("R1 shadow rb", v, 0);

        // R2 shadow writes, R4 hold without strobe
        cyc(1, 3'd0, 16'h1111, 0); cyc(1, 3'd1, 16'h2222, 0);
        cyc(1, 3'd2, 16'h3333, 0); cyc(1, 3'd3, 16'h4444, 0);
        rd(3'd0, v); chk("R2 rd ra", v, 16'h1111);
        rd(3'd3, v); chk("R2 rd sb", v, 16'h4444);
        chk("R4 hold no strobe", act_ra, 0);
        cyc(0, 3'd0, 0, 1);
        chk("R4 xfer ra", act_ra, 16'h1111); chk("R4 xfer sb", act_sb, 16'h4444);

        // R3 exported fields: ramp four (10), polarity high, clock select
        cyc(1, 3'd4, 16'h0016, 0);
        chk("R3 ramp", ramp_mode, 2'b10); chk("R3 pol", pol_high, 1); chk("R3 clksel", clk_sel, 1);
        rd(3'd4, v); chk("R3 rd cfg", v, 16'h0016);

        // R2 unmapped address ignored
        cyc(1, 3'd5, 16'hBEEF, 0);
        rd(3'd5, v); chk("R2 rd unmapped", v, 0);
        rd(3'd0, v); chk("R2 unmapped no effect", v, 16'h1111);

        // R5 lock, R6 release
        cyc(1, 3'd4, 16'h0020, 0);
        cyc(1, 3'd0, 16'hA0A0, 0); cyc(1, 3'd1, 16'hB0B0, 0);
        cyc(0, 3'd0, 0, 1); cyc(0, 3'd0, 0, 1);
        chk("R5 locked ra", act_ra, 16'h1111); chk("R5 locked rb", act_rb, 16'h2222);
        cyc(1, 3'd4, 16'h0000, 0);
        chk("R6 wait strobe", act_ra, 16'h1111);
        cyc(0, 3'd0, 0, 1);
        chk("R6 release ra", act_ra, 16'hA0A0); chk("R6 release rb", act_rb, 16'hB0B0);

        // R7 auto-lock
        cyc(1, 3'd4, 16'h0040, 0);
        cyc(1, 3'd0, 16'hC0C0, 0);
        cyc(0, 3'd0, 0, 1);
        chk("R7 no rb write", act_ra, 16'hA0A0);
        cyc(1, 3'd1, 16'hD0D0, 0);
        cyc(0, 3'd0, 0, 1);
        chk("R7 rb last ra", act_ra, 16'hC0C0); chk("R7 rb last rb", act_rb, 16'hD0D0);
        cyc(1, 3'd1, 16'hE0E0, 0); cyc(1, 3'd2, 16'hF0F0, 0);
        cyc(0, 3'd0, 0, 1);
        chk("R7 cancelled rb", act_rb, 16'hD0D0); chk("R7 cancelled sa", act_sa, 16'h3333);

        // R8 auto-lock prevails over lock
        cyc(1, 3'd4, 16'h0060, 0);
        cyc(1, 3'd1, 16'h1234, 0);
        cyc(0, 3'd0, 0, 1);
        chk("R8 prio rb", act_rb, 16'h1234); chk("R8 prio sa", act_sa, 16'hF0F0);

        // R9 fifty-percent mode
        cyc(1, 3'd4, 16'h0080, 0);
        cyc(1, 3'd3, 16'h0055, 0); cyc(1, 3'd1, 16'h0077, 0);
        rd(3'd0, v); chk("R9 mirror ra", v, 16'h0077);
        rd(3'd2, v); chk("R9 mirror sa", v, 16'h0055);
        cyc(1, 3'd0, 16'h9999, 0);
        rd(3'd0, v); chk("R9 ra ignored", v, 16'h0077);
        cyc(0, 3'd0, 0, 1);
        chk("R9 act ra", act_ra, 16'h0077); chk("R9 act sa", act_sa, 16'h0055);

        // R10 write and strobe together
        cyc(1, 3'd4, 16'h0000, 0);
        cyc(1, 3'd3, 16'h5A5A, 1);
        chk("R10 old value", act_sb, 16'h0055);
        cyc(0, 3'd0, 0, 1);
        chk("R10 new value", act_sb, 16'h5A5A);
        cmp_model("R2 R9 model sync");

        // Random phase against the bench model
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] a;
            a = 3'($urandom % 7);
            if (a == 3'd4 && ($urandom % 3) != 0) a = 3'd1;
            cyc(1'($urandom % 2), a, 16'($urandom), ($urandom % 4) == 0);
            cmp_model("R4 R5 R6 R7 R8 R9 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule